// File: doc/BRIEF.md
# Flash Status Register Protection Controller

This block holds the 24-bit status and configuration word of a serial NOR flash and decides, command by command, whether a state-changing request may proceed. It sits behind the command decoder, which hands it one-cycle strobes: set or clear the write-enable latch, write the status word (with a 16-bit payload), program a page, and erase a sector, a block or the whole chip. It also sees the active-low protection pin and two synchronous resets. The first resets the whole block, including the non-volatile fields, to their factory state. The second models a power cycle and clears only the volatile state.

Every strobe gets a verdict one clock later, as a one-cycle accept or reject pulse. An accepted status write, program or erase starts a busy interval of a configurable number of cycles. At the end of that interval the write-enable latch drops by itself. A two-bit lock mode, combined with the protection pin, controls status writes. Four modes are available: software-only, pin-gated, locked until the next power cycle, and permanently locked. Chip erase is also checked against the protect bits and the invert flag.

Top module: `flash_sr_guard`

## Requirements
- R1: `status_o` layout:
  - bit 0 is busy and bit 1 is the write-enable latch.
  - Bits 6:2 are the protect bits PB[4:0].
  - Bits 8:7 are the lock mode, with bit 8 the high bit.
  - Bit 9 is quad enable, bits 13:11 are the one-time lock bits and bit 14 is the protect-invert flag.
  - Bits 10 and 15 (suspend) always read 0.
  - Bit 20 is the high-performance flag and bits 22:21 are the drive strength, both fixed by parameters.
  - Bits 19:16 and 23 read 0.
- R2: An enable strobe sets the latch when not busy. A disable strobe is always accepted and clears the latch at the next edge, even while busy.
- R3: With the latch at 0, a status write, a page program or any erase is rejected and changes no state.
- R4: An accepted status write, program or erase makes `busy` 1 for exactly BUSY_CYCLES cycles, starting one edge after the strobe. The latch is 0 from the edge at which `busy` falls.
- R5: While busy, every strobe other than disable is rejected and changes no state.
- R6: A status write with the latch set is gated by the lock mode:
  - Lock mode 00 accepts it.
  - Lock mode 01 accepts it only while the protection pin is 1. With the pin at 0 it is rejected and the protect bits stay unchanged.
- R7: Lock mode 10 rejects status writes. A power-cycle reset returns the lock mode to 00, clears the latch and busy, and keeps every other stored field.
- R8: Lock mode 11 rejects status writes, and a power-cycle reset leaves it at 11.
- R9: With the latch set, a chip erase is accepted only when PB[2:0]=000 with invert=0, or PB[2:0]=111 with invert=1. Program, sector erase and block erase need only the latch.
- R10: An accepted status write loads payload bits 9:2 and 14 into the matching fields. Payload bits 13:11 are OR-ed into the one-time lock bits, which never clear. Payload bits 0, 1, 10 and 15 are ignored.
- R11: Each strobe cycle produces exactly one of `cmd_accept` or `cmd_reject` at the next edge. Simultaneous strobes are resolved by priority: disable, enable, status write, chip erase, block erase, sector erase, program.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| nv_init_n | input | 1 | Synchronous factory reset of all state, active low |
| pwr_rst_n | input | 1 | Synchronous power-cycle reset of volatile state, active low |
| prot_pin_n | input | 1 | Protection pin, low means protect |
| cmd_wr_en | input | 1 | Set write-enable latch strobe |
| cmd_wr_dis | input | 1 | Clear write-enable latch strobe |
| cmd_sr_write | input | 1 | Status write strobe |
| sr_wdata | input | 16 | Status write payload |
| cmd_prog | input | 1 | Page program strobe |
| cmd_sect_erase | input | 1 | Sector erase strobe |
| cmd_blk_erase | input | 1 | Block erase strobe |
| cmd_chip_erase | input | 1 | Chip erase strobe |
| status_o | output | 24 | Status word |
| cmd_accept | output | 1 | Previous-cycle strobe accepted |
| cmd_reject | output | 1 | Previous-cycle strobe rejected |
| busy | output | 1 | Operation in progress |

## Verification
The bound checker watches several properties on every cycle:
- Reserved and suspend bits stay zero, and accept and reject are never high together.
- A disable strobe clears the latch, and a status write without the latch is rejected.
- Stored fields are frozen while busy, the latch is low when busy falls, and the permanent lock never leaves mode 11.

Only the bench scenarios can show the mode-by-pin-by-latch decision table and the exact busy length. The same applies to how each lock mode behaves across a power cycle, the chip-erase condition over all protect and invert combinations, the sticky one-time bits, and strobe priority.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_WDIS,
        CMD_WEN,
        CMD_SRW,
        CMD_CHIP,
        CMD_BLK,
        CMD_SECT,
        CMD_PROG
    } cmd_e;

    localparam logic [1:0] LOCK_SW  = 2'b00;
    localparam logic [1:0] LOCK_PIN = 2'b01;
    localparam logic [1:0] LOCK_PWR = 2'b10;
    localparam logic [1:0] LOCK_OTP = 2'b11;

    typedef struct packed {
        logic       prot_inv;
        logic [2:0] otp_lock;
        logic       quad_en;
        logic [1:0] lock_mode;
        logic [4:0] prot_bits;
    } nv_t;

    typedef struct packed {
        nv_t  nv;
        logic wel;
        logic acc;
        logic rej;
    } regs_t;

    localparam nv_t NV_FACTORY = '0;

endpackage

// File: rtl/fsr_cmd_pick.sv
module fsr_cmd_pick
    import fsr_pkg::*;
(
    input  logic wr_dis,
    input  logic wr_en,
    input  logic sr_write,
    input  logic chip_erase,
    input  logic blk_erase,
    input  logic sect_erase,
    input  logic prog,
    output cmd_e cmd
);
    // R11: fixed priority among simultaneous strobes
    always_comb begin
        if (wr_dis)          cmd = CMD_WDIS;
        else if (wr_en)      cmd = CMD_WEN;
        else if (sr_write)   cmd = CMD_SRW;
        else if (chip_erase) cmd = CMD_CHIP;
        else if (blk_erase)  cmd = CMD_BLK;
        else if (sect_erase) cmd = CMD_SECT;
        else if (prog)       cmd = CMD_PROG;
        else                 cmd = CMD_NONE;
    end
endmodule

// File: rtl/fsr_grant.sv
module fsr_grant
    import fsr_pkg::*;
(
    input  cmd_e cmd,
    input  nv_t  nv,
    input  logic wel,
    input  logic busy,
    input  logic prot_pin_n,
    output logic grant
);
    logic sr_open;
    logic chip_ok;

    always_comb begin
        unique case (nv.lock_mode)
            LOCK_SW:  sr_open = 1'b1;
            LOCK_PIN: sr_open = prot_pin_n;
            default:  sr_open = 1'b0;
        endcase
        chip_ok = ((nv.prot_bits[2:0] == 3'b000) && !nv.prot_inv) ||
                  ((nv.prot_bits[2:0] == 3'b111) &&  nv.prot_inv);

        grant = 1'b0;
        if (cmd == CMD_WDIS) begin
            grant = 1'b1;
        end else if (!busy) begin
            unique case (cmd)
                CMD_WEN:  grant = 1'b1;
                CMD_SRW:  grant = wel && sr_open;
                CMD_CHIP: grant = wel && chip_ok;
                CMD_BLK,
                CMD_SECT,
                CMD_PROG: grant = wel;
                default:  grant = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/fsr_busy_timer.sv
module fsr_busy_timer #(
    parameter int unsigned CYCLES = 1000
) (
    input  logic clk,
    input  logic clr,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int unsigned CW = $clog2(CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(CYCLES - 1);

    typedef struct packed {
        logic          run;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (start) begin
            tmr_d.run = 1'b1;
            tmr_d.cnt = LOAD;
        end else if (tmr_q.run) begin
            if (tmr_q.cnt == '0) tmr_d.run = 1'b0;
            else                 tmr_d.cnt = tmr_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (clr) tmr_q <= '0;
        else     tmr_q <= tmr_d;
    end

    assign busy = tmr_q.run;
    assign done = tmr_q.run && (tmr_q.cnt == '0);
endmodule

// File: rtl/flash_sr_guard.sv
module flash_sr_guard
    import fsr_pkg::*;
#(
    parameter int unsigned BUSY_CYCLES = 1000,
    parameter logic [1:0]  DRV_INIT    = 2'b00,
    parameter logic        HPF_INIT    = 1'b0
) (
    input  logic        clk,
    input  logic        nv_init_n,
    input  logic        pwr_rst_n,
    input  logic        prot_pin_n,
    input  logic        cmd_wr_en,
    input  logic        cmd_wr_dis,
    input  logic        cmd_sr_write,
    input  logic [15:0] sr_wdata,
    input  logic        cmd_prog,
    input  logic        cmd_sect_erase,
    input  logic        cmd_blk_erase,
    input  logic        cmd_chip_erase,
    output logic [23:0] status_o,
    output logic        cmd_accept,
    output logic        cmd_reject,
    output logic        busy
);
    regs_t r_d, r_q;
    cmd_e  cmd;
    logic  grant;
    logic  op_busy;
    logic  op_done;
    logic  op_start;
    logic  tmr_clr;

    fsr_cmd_pick u_pick (
        .wr_dis     (cmd_wr_dis),
        .wr_en      (cmd_wr_en),
        .sr_write   (cmd_sr_write),
        .chip_erase (cmd_chip_erase),
        .blk_erase  (cmd_blk_erase),
        .sect_erase (cmd_sect_erase),
        .prog       (cmd_prog),
        .cmd        (cmd)
    );

    fsr_grant u_grant (
        .cmd        (cmd),
        .nv         (r_q.nv),
        .wel        (r_q.wel),
        .busy       (op_busy),
        .prot_pin_n (prot_pin_n),
        .grant      (grant)
    );

    assign tmr_clr = !nv_init_n || !pwr_rst_n;

    fsr_busy_timer #(.CYCLES(BUSY_CYCLES)) u_timer (
        .clk   (clk),
        .clr   (tmr_clr),
        .start (op_start),
        .busy  (op_busy),
        .done  (op_done)
    );

    always_comb begin
        r_d      = r_q;
        op_start = 1'b0;
        r_d.acc  = (cmd != CMD_NONE) && grant;
        r_d.rej  = (cmd != CMD_NONE) && !grant;

        // R4: latch drops when the operation finishes
        if (op_done) r_d.wel = 1'b0;

        if (grant) begin
            unique case (cmd)
                CMD_WDIS: r_d.wel = 1'b0;
                CMD_WEN:  r_d.wel = 1'b1;
                CMD_SRW: begin
                    // R10: field load; one-time bits only accumulate
                    r_d.nv.prot_bits = sr_wdata[6:2];
                    r_d.nv.lock_mode = sr_wdata[8:7];
                    r_d.nv.quad_en   = sr_wdata[9];
                    r_d.nv.otp_lock  = r_q.nv.otp_lock | sr_wdata[13:11];
                    r_d.nv.prot_inv  = sr_wdata[14];
                    op_start         = 1'b1;
                end
                CMD_CHIP, CMD_BLK, CMD_SECT, CMD_PROG: op_start = 1'b1;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!nv_init_n) begin
            r_q <= '{nv: NV_FACTORY, wel: 1'b0, acc: 1'b0, rej: 1'b0};
        end else if (!pwr_rst_n) begin
            // R7: power cycle releases only the until-power-cycle lock
            r_q.wel <= 1'b0;
            r_q.acc <= 1'b0;
            r_q.rej <= 1'b0;
            if (r_q.nv.lock_mode == LOCK_PWR) r_q.nv.lock_mode <= LOCK_SW;
        end else begin
            r_q <= r_d;
        end
    end

    // R1: status word assembly
    assign status_o = {1'b0, DRV_INIT, HPF_INIT, 4'b0000,
                       1'b0, r_q.nv.prot_inv, r_q.nv.otp_lock, 1'b0,
                       r_q.nv.quad_en, r_q.nv.lock_mode, r_q.nv.prot_bits,
                       r_q.wel, op_busy};
    assign cmd_accept = r_q.acc;
    assign cmd_reject = r_q.rej;
    assign busy       = op_busy;
endmodule

// File: rtl/fsr_guard_chk.sv
module fsr_guard_chk (
    input logic        clk,
    input logic        nv_init_n,
    input logic        pwr_rst_n,
    input logic        cmd_wr_en,
    input logic        cmd_wr_dis,
    input logic        cmd_sr_write,
    input logic [23:0] status_o,
    input logic        cmd_accept,
    input logic        cmd_reject,
    input logic        busy
);
    // R1
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!nv_init_n || !pwr_rst_n)
        (status_o[23] == 1'b0) && (status_o[19:16] == 4'h0) && !status_o[15] && !status_o[10]);

    // R11
    one_verdict_chk: assert property (@(posedge clk) disable iff (!nv_init_n || !pwr_rst_n)
        !(cmd_accept && cmd_reject));

    // R2
    disable_clears_chk: assert property (@(posedge clk) disable iff (!nv_init_n || !pwr_rst_n)
        cmd_wr_dis |=> (!status_o[1] && cmd_accept));

    // R3
    no_latch_reject_chk: assert property (@(posedge clk) disable iff (!nv_init_n || !pwr_rst_n)
        (cmd_sr_write && !cmd_wr_en && !cmd_wr_dis && !status_o[1]) |=> cmd_reject);

    // R4
    latch_low_at_end_chk: assert property (@(posedge clk) disable iff (!nv_init_n || !pwr_rst_n)
        $fell(busy) |-> !status_o[1]);

    // R5
    frozen_while_busy_chk: assert property (@(posedge clk) disable iff (!nv_init_n || !pwr_rst_n)
        busy |=> $stable(status_o[14:2]));

    // R8
    otp_lock_stays_chk: assert property (@(posedge clk) disable iff (!nv_init_n || !pwr_rst_n)
        (status_o[8:7] == 2'b11) |=> (status_o[8:7] == 2'b11));
endmodule

bind flash_sr_guard fsr_guard_chk u_chk (
    .clk          (clk),
    .nv_init_n    (nv_init_n),
    .pwr_rst_n    (pwr_rst_n),
    .cmd_wr_en    (cmd_wr_en),
    .cmd_wr_dis   (cmd_wr_dis),
    .cmd_sr_write (cmd_sr_write),
    .status_o     (status_o),
    .cmd_accept   (cmd_accept),
    .cmd_reject   (cmd_reject),
    .busy         (busy)
);

// File: tb/flash_sr_guard_tb.sv
module flash_sr_guard_tb;
    localparam int BUSY_N = 4;
    localparam logic [6:0] M_DIS = 7'd1, M_EN = 7'd2, M_SRW = 7'd4, M_CE = 7'd8,
                           M_BE = 7'd16, M_SE = 7'd32, M_PG = 7'd64;

    logic        clk = 1'b0;
    logic        nv_init_n = 1'b0, pwr_rst_n = 1'b0, prot_pin_n = 1'b1;
    logic        cmd_wr_en = 0, cmd_wr_dis = 0, cmd_sr_write = 0;
    logic        cmd_prog = 0, cmd_sect_erase = 0, cmd_blk_erase = 0, cmd_chip_erase = 0;
    logic [15:0] sr_wdata = '0;
    logic [23:0] status_o;
    logic        cmd_accept, cmd_reject, busy;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    flash_sr_guard #(.BUSY_CYCLES(BUSY_N), .DRV_INIT(2'b10), .HPF_INIT(1'b1)) u_dut (.*);

    task automatic check(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic issue(input logic [6:0] m, input logic [15:0] data);
        @(negedge clk);
        {cmd_prog, cmd_sect_erase, cmd_blk_erase, cmd_chip_erase,
         cmd_sr_write, cmd_wr_en, cmd_wr_dis} = m;
        sr_wdata = data;
        @(negedge clk);
        {cmd_prog, cmd_sect_erase, cmd_blk_erase, cmd_chip_erase,
         cmd_sr_write, cmd_wr_en, cmd_wr_dis} = '0;
    endtask

    task automatic drain(output int n);
        n = 0;
        while (busy) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic do_reset(input bit full);
        @(negedge clk);
        if (full) nv_init_n = 1'b0;
        pwr_rst_n = 1'b0;
        @(negedge clk);
        nv_init_n = 1'b1;
        pwr_rst_n = 1'b1;
    endtask

    task automatic sr_set(input logic [15:0] data);
        int n;
        issue(M_EN, 16'h0);
        issue(M_SRW, data);
        drain(n);
    endtask

    initial begin
        int n;
        bit exp_ok;
        do_reset(1'b1);
        // R1: reset value with parameter-fixed upper fields
        check("R1 reset status", int'(status_o), 24'h500000);
        check("R1 reset busy", int'(busy), 0);

        // R3: status write without latch
        issue(M_SRW, 16'h007C);
        check("R3 reject", int'(cmd_reject), 1);
        check("R3 state", int'(status_o), 24'h500000);
        issue(M_PG, 16'h0);
        check("R3 program reject", int'(cmd_reject), 1);
        check("R3 no busy", int'(busy), 0);

        // R2: enable and disable
        issue(M_EN, 16'h0);
        check("R2 enable accept", int'(cmd_accept), 1);
        check("R2 latch set", int'(status_o[1]), 1);
        issue(M_DIS, 16'h0);
        check("R2 latch cleared", int'(status_o[1]), 0);

        // R4 / R5: busy length, commands while busy
        issue(M_EN, 16'h0);
        issue(M_PG, 16'h0);
        check("R4 program accept", int'(cmd_accept), 1);
        issue(M_EN, 16'h0);
        check("R5 enable while busy rejected", int'(cmd_reject), 1);
        issue(M_SRW, 16'h007C);
        check("R5 write while busy rejected", int'(cmd_reject), 1);
        check("R5 fields unchanged", int'(status_o[6:2]), 0);
        drain(n);
        check("R4 busy length", n + 4, BUSY_N);
        check("R4 latch auto clear", int'(status_o[1]), 0);

        issue(M_EN, 16'h0);
        issue(M_SE, 16'h0);
        check("R9 sector erase accept", int'(cmd_accept), 1);
        issue(M_DIS, 16'h0);
        check("R2 disable while busy accepted", int'(cmd_accept), 1);
        check("R2 latch clear while busy", int'(status_o[1]), 0);
        drain(n);
        issue(M_EN, 16'h0);
        issue(M_BE, 16'h0);
        check("R9 block erase accept", int'(cmd_accept), 1);
        drain(n);
        check("R4 busy length block", n, BUSY_N);

        // R6 / R7 / R8: lock mode x pin x latch sweep
        for (int s = 0; s < 4; s++) begin
            for (int w = 0; w < 2; w++) begin
                for (int l = 0; l < 2; l++) begin
                    do_reset(1'b1);
                    prot_pin_n = 1'b1;
                    sr_set(16'(s << 7));
                    check("R6 lock mode loaded", int'(status_o[8:7]), s);
                    prot_pin_n = w[0];
                    if (l != 0) issue(M_EN, 16'h0);
                    issue(M_SRW, 16'(s << 7) | 16'h0054);
                    exp_ok = (l != 0) && ((s == 0) || (s == 1 && w == 1));
                    check($sformatf("R6 R7 R8 verdict s=%0d pin=%0d wel=%0d", s, w, l),
                          int'(cmd_accept), int'(exp_ok));
                    drain(n);
                    check($sformatf("R6 protect bits s=%0d pin=%0d wel=%0d", s, w, l),
                          int'(status_o[6:2]), exp_ok ? 5'h15 : 5'h00);
                    if (s >= 2 && w == 1 && l == 1) begin
                        issue(M_EN, 16'h0);
                        do_reset(1'b0);
                        check(s == 2 ? "R7 lock after power cycle" : "R8 lock after power cycle",
                              int'(status_o[8:7]), s == 2 ? 0 : 3);
                        check("R7 latch cleared by power cycle", int'(status_o[1]), 0);
                        prot_pin_n = 1'b1;
                        issue(M_EN, 16'h0);
                        issue(M_SRW, 16'h0008);
                        check(s == 2 ? "R7 write after release" : "R8 still locked",
                              int'(cmd_accept), s == 2 ? 1 : 0);
                        drain(n);
                    end
                end
            end
        end

        // R9: chip erase condition sweep
        prot_pin_n = 1'b1;
        for (int b = 0; b < 8; b++) begin
            for (int c = 0; c < 2; c++) begin
                do_reset(1'b1);
                sr_set(16'((b << 2) | (c << 14)));
                issue(M_EN, 16'h0);
                issue(M_CE, 16'h0);
                exp_ok = (b == 0 && c == 0) || (b == 7 && c == 1);
                check($sformatf("R9 chip erase pb=%0d inv=%0d", b, c),
                      int'(cmd_accept), int'(exp_ok));
                check("R9 busy matches verdict", int'(busy), int'(exp_ok));
                drain(n);
            end
        end

        // R10: field mapping and sticky one-time bits
        do_reset(1'b1);
        sr_set(16'h3800);
        sr_set(16'h0000);
        check("R10 one-time bits stick", int'(status_o[13:11]), 7);
        do_reset(1'b1);
        sr_set(16'hFFFF);
        check("R10 all-ones mapping", int'(status_o[15:0]), 16'h7BFC);
        check("R1 upper fields", int'(status_o[23:16]), 8'h50);

        // R11: priority between simultaneous strobes
        do_reset(1'b1);
        sr_set(16'h0004);
        issue(M_EN, 16'h0);
        issue(M_EN | M_DIS, 16'h0);
        check("R11 disable wins", int'(status_o[1]), 0);
        check("R11 verdict accept", int'(cmd_accept), 1);
        issue(M_EN, 16'h0);
        issue(M_PG | M_CE, 16'h0);
        check("R11 chip erase outranks program", int'(cmd_reject), 1);
        check("R11 no busy", int'(busy), 0);
        check("R11 latch kept", int'(status_o[1]), 1);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule